// File: doc/BRIEF.md
# Serial-to-Parallel Word Receiver with Adjustable Bit Delay

This block turns a single-bit serial stream, sampled on a fast bit clock, into parallel words `WORD_W` bits wide. A capture pulse on `load_en`, supplied by the clock generator once every `WORD_W` bit-clock cycles, marks the instant at which the assembled word is copied to the output. Between two capture pulses the output word holds its value, so it behaves as a word in the slow parallel clock domain.

To find the word boundary, a programmable bit delay sits in front of the shift register. Each rising edge on the asynchronous `slip_req` input adds one bit-clock of latency. After `SLIP_ROLL` slips the latency wraps back to zero. A look-ahead flag, `slip_max`, tells the alignment logic that the next slip will wrap. An asynchronous `slip_rst` returns the latency to zero at any moment. Alignment logic typically compares the output word with a known control pattern and issues slips until the pattern appears.

Top module: `slip_deserializer`

## Requirements
- R1: The word width `WORD_W` is a parameter from 3 to 10. `word_out` is updated only on a bit-clock edge at which `load_en` is high, and otherwise holds its value.
- R2: The earliest bit of a word lands in the most significant position. With latency L, a word captured at edge t has `word_out[i]` equal to the serial bit sampled at edge t-1-i-L.
- R3: `slip_req` passes through a synchronizer of `SYNC_STAGES` flops. Each low-to-high transition adds exactly one step, however long the input stays high.
- R4: Each counted slip raises the added latency by exactly one bit-clock cycle.
- R5: When the latency is `SLIP_ROLL`-1, the next slip returns it to zero. `SLIP_ROLL` must be at least `WORD_W` and defaults to `WORD_W`.
- R6: `slip_rst` is asynchronous and active high. It returns the latency to zero at any time, and `slip_max` drops without waiting for a clock edge.
- R7: `slip_max` is high exactly when the latency equals `SLIP_ROLL`-1. It follows a latency change after `STAT_STAGES` bit-clock cycles, which is within five word periods.
- R8: Once a slip has taken effect, the output words follow the formula of R2 again within two capture pulses.
- R9: The synchronous, active-high `rst` clears `word_out` and `slip_max` to zero and sets the latency to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| load_en | input | 1 | Word capture pulse, once per WORD_W cycles |
| slip_req | input | 1 | Asynchronous slip request, counted on its rising edge |
| slip_rst | input | 1 | Asynchronous active-high reset of the bit delay |
| word_out | output | WORD_W | Parallel word, first bit in the MSB |
| slip_max | output | 1 | High when the next slip wraps the delay to zero |

## Verification
The in-line properties are checked on every clock cycle. They cover four things:
- the counter steps by one per counted slip, wraps at the rollover point and holds when no slip is counted;
- a synchronized request yields a single pulse;
- the output word holds between capture pulses;
- its LSB is the bit presented at the capture edge.

Other behaviours can only be shown by the bench's scenarios, because they need an independent model of the serial history:
- the full word content at every latency value, including the wrap;
- a long-held request counting once;
- the asynchronous fall of `slip_max` on `slip_rst`;
- the flag tracking the rollover point.

// File: rtl/slip_deser_pkg.sv
package slip_deser_pkg;

  // Width of an index able to address n entries (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  localparam int unsigned MIN_WORD = 3;
  localparam int unsigned MAX_WORD = 10;

endpackage

// File: rtl/slip_req_sync.sv
module slip_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic step
);
  // One extra flop holds the previous synchronized level for edge detection.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= req_async;
      for (int s = 1; s <= STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign step = pipe[STAGES-1] & ~pipe[STAGES];

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

endmodule

// File: rtl/slip_counter.sv
module slip_counter
  import slip_deser_pkg::*;
#(
  parameter int unsigned ROLL        = 8,
  parameter int unsigned STAT_STAGES = 2,
  localparam int unsigned CW         = idx_w(ROLL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slip_rst,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          at_max
);
  localparam logic [CW-1:0] TOP = CW'(ROLL - 1);

  logic                   top_now;
  logic [STAT_STAGES-1:0] stat;

  assign top_now = (cnt == TOP);

  always_ff @(posedge clk or posedge slip_rst) begin
    if (slip_rst) begin
      cnt <= '0;
    end else if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= top_now ? '0 : cnt + 1'b1;
    end
  end

  // Status pipeline: a fixed, short delay from the count to the flag.
  always_ff @(posedge clk or posedge slip_rst) begin
    if (slip_rst) begin
      stat <= '0;
    end else if (rst) begin
      stat <= '0;
    end else begin
      stat[0] <= top_now;
      for (int s = 1; s < STAT_STAGES; s++) begin
        stat[s] <= stat[s-1];
      end
    end
  end

  assign at_max = stat[STAT_STAGES-1];

  // R4
  slip_step_chk: assert property (@(posedge clk) disable iff (rst || slip_rst)
    (step && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

  // R5
  slip_wrap_chk: assert property (@(posedge clk) disable iff (rst || slip_rst)
    (step && cnt == TOP) |=> cnt == '0);

  // R3
  slip_hold_chk: assert property (@(posedge clk) disable iff (rst || slip_rst)
    !step |=> $stable(cnt));

endmodule

// File: rtl/bit_delay_line.sv
module bit_delay_line
  import slip_deser_pkg::*;
#(
  parameter int unsigned TAPS = 8,
  localparam int unsigned CW  = idx_w(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [CW-1:0] sel,
  output logic          dout
);
  // tap[k] holds the input bit sampled k+1 edges ago.
  logic [TAPS-1:0] tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap <= '0;
    end else begin
      tap <= {tap[TAPS-2:0], din};
    end
  end

  assign dout = tap[sel];

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             load_en,
  output logic [WIDTH-1:0] word_out
);
  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] next_word;

  // The newest bit enters at the LSB, so the first bit ends up in the MSB.
  assign next_word = {shreg[WIDTH-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      word_out <= '0;
    end else begin
      shreg <= next_word;
      if (load_en) begin
        word_out <= next_word;
      end
    end
  end

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(word_out));

  // R2
  word_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> word_out[0] == $past(bit_in));

endmodule

// File: rtl/slip_deserializer.sv
module slip_deserializer
  import slip_deser_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SLIP_ROLL   = WORD_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAT_STAGES = 2
) (
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              load_en,
  input  logic              slip_req,
  input  logic              slip_rst,
  output logic [WORD_W-1:0] word_out,
  output logic              slip_max
);
  localparam int unsigned CW = idx_w(SLIP_ROLL);

  logic          step;
  logic [CW-1:0] delay_sel;
  logic          delayed_bit;

  slip_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk_bit),
    .rst       (rst),
    .req_async (slip_req),
    .step      (step)
  );

  slip_counter #(.ROLL(SLIP_ROLL), .STAT_STAGES(STAT_STAGES)) u_cnt (
    .clk      (clk_bit),
    .rst      (rst),
    .slip_rst (slip_rst),
    .step     (step),
    .cnt      (delay_sel),
    .at_max   (slip_max)
  );

  bit_delay_line #(.TAPS(SLIP_ROLL)) u_dly (
    .clk  (clk_bit),
    .rst  (rst),
    .din  (ser_in),
    .sel  (delay_sel),
    .dout (delayed_bit)
  );

  word_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk      (clk_bit),
    .rst      (rst),
    .bit_in   (delayed_bit),
    .load_en  (load_en),
    .word_out (word_out)
  );

  // R5
  roll_param_chk: assert final (SLIP_ROLL >= WORD_W);
  // R1
  width_param_chk: assert final (WORD_W >= MIN_WORD && WORD_W <= MAX_WORD);

endmodule

// File: tb/slip_deserializer_test.sv
`timescale 1ns/1ps
module slip_deserializer_test;
  localparam int J    = 4;
  localparam int ROLL = 5;

  logic clk = 1'b0, rst = 1'b1, ser_in = 1'b0, load_en = 1'b0;
  logic slip_req = 1'b0, slip_rst = 1'b0;
  logic [J-1:0] word_out;
  logic slip_max;

  slip_deserializer #(.WORD_W(J), .SLIP_ROLL(ROLL)) uut (
    .clk_bit(clk), .rst(rst), .ser_in(ser_in), .load_en(load_en),
    .slip_req(slip_req), .slip_rst(slip_rst),
    .word_out(word_out), .slip_max(slip_max)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, expcnt = 0;
  bit chk_en = 0, have_last = 0;
  logic [J-1:0] last_word, expw;

  function automatic logic pat(input int n);
    logic [31:0] h;
    h = n * 32'h9E3779B1;
    return h[17] ^ h[5];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Drive and monitor, both keyed only on the edge counter.
  always @(negedge clk) begin
    if (chk_en) begin
      if (cyc % J == 0) begin
        for (int i = 0; i < J; i++) expw[i] = pat(cyc - 1 - i - expcnt);
        // R2 word order at this latency; R4/R5/R8 once slips have settled
        check(word_out == expw, "R2 word content", int'(word_out), int'(expw));
        // R7
        check(slip_max == (expcnt == ROLL - 1), "R7 slip_max", int'(slip_max),
              int'(expcnt == ROLL - 1));
        last_word = word_out;
        have_last = 1;
      end else if (have_last) begin
        // R1 hold between capture pulses
        check(word_out == last_word, "R1 hold", int'(word_out), int'(last_word));
      end
    end else begin
      have_last = 0;
    end
    ser_in  = pat(cyc + 1);
    load_en = ((cyc + 1) % J == 0);
  end

  task automatic settle();
    repeat (4 * J + ROLL + 10) @(negedge clk);
    chk_en = 1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_slip(input int hold);
    chk_en = 0;
    @(negedge clk);
    slip_req = 1;
    repeat (hold) @(negedge clk);
    slip_req = 0;
    expcnt = (expcnt + 1) % ROLL;
    settle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check(word_out == '0, "R9 word reset", int'(word_out), 0);
    check(slip_max == 1'b0, "R9 slip_max reset", int'(slip_max), 0);
    rst = 0;
    settle();
    run(40);
    // R4 and R5: sweep every latency value and wrap past the rollover point
    for (int k = 0; k <= ROLL; k++) begin
      do_slip(1);
      run(24);
    end
    // R3: a request held high for many cycles counts once
    do_slip(30);
    run(24);
    while (expcnt != ROLL - 1) begin
      do_slip(2);
      run(12);
    end
    // R6: asynchronous slip reset while at the rollover point
    chk_en = 0;
    @(negedge clk);
    check(slip_max == 1'b1, "R7 slip_max at top", int'(slip_max), 1);
    #3 slip_rst = 1;
    #2 check(slip_max == 1'b0, "R6 async clear", int'(slip_max), 0);
    @(negedge clk);
    @(negedge clk);
    slip_rst = 0;
    expcnt = 0;
    settle();
    run(24);
    // R5: one more slip after the reset starts again from zero
    do_slip(1);
    run(24);
    finish_run();
  end
endmodule